// File: doc/BRIEF.md
# Instruction Decoder and Control Unit

This block sits between the instruction fetch path and the datapath of a 16-bit single-cycle processor with eight 16-bit registers. It takes one 16-bit instruction word and, in the same cycle with no registers, produces three register specifiers, a sign-extended immediate, and the control lines that steer the register file, the ALU, the data memory and the next-PC logic. Those units are outside the block.

The top four bits of the word select the operation. Every format shares one layout: two 3-bit register fields below the opcode, then either a third register field or a 6-bit offset. The decoder always drives both source specifiers and the immediate. It picks the destination field according to the instruction class, so the datapath never has to look at the opcode. Reserved opcodes decode to a no-operation that changes no architectural state.

Top module: `isa_decoder`

## Requirements
- R1: `src_a_o` always equals instruction bits [11:9] and `src_b_o` always equals bits [8:6], for every opcode. The opcode is bits [15:12].
- R2: `dst_o` equals bits [5:3] for the ALU opcodes 0010 through 1001. It equals bits [8:6] for load (0000).
- R3: `imm_o` is bits [5:0] sign-extended to 16 bits: bits [15:6] all copy bit 5.
- R4: `reg_we_o` is 1 for load and for the eight ALU opcodes 0010 to 1001, and 0 for every other opcode.
- R5: Load (0000) drives `mem_rd_o`=1, `wb_mem_o`=1 and `alu_op_o`=0 (add). No other opcode drives `mem_rd_o` or `wb_mem_o`.
- R6: Store (0001) drives `mem_wr_o`=1 and `alu_op_o`=0 (add). No other opcode drives `mem_wr_o`.
- R7: `alu_op_o` encodes the operation as add=0, subtract=1, invert=2, shift-left=3, shift-right=4, AND=5, OR=6, set-less-than=7. These map to opcodes 0010, 0011, 0100, 0101, 0110, 0111, 1000 and 1001 in that order.
- R8: Opcode 1011 drives `br_eq_o`=1 and opcode 1100 drives `br_ne_o`=1, both with `alu_op_o`=1 (subtract). No other opcode drives either line.
- R9: Opcode 1101 drives `jump_o`=1. No other opcode drives it.
- R10: Opcodes 1010, 1110 and 1111 drive every enable (`reg_we_o`, `mem_rd_o`, `mem_wr_o`, `wb_mem_o`, `br_eq_o`, `br_ne_o`, `jump_o`) to 0, and drive `alu_op_o` to 0.
- R11: At most one of `mem_wr_o`, `br_eq_o`, `br_ne_o` and `jump_o` is 1 at any time, and `mem_rd_o` is never 1 together with `mem_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| src_a_o | output | 3 | First source / base register specifier |
| src_b_o | output | 3 | Second source / store data / compare register specifier |
| dst_o | output | 3 | Destination register specifier |
| imm_o | output | 16 | Sign-extended 6-bit offset |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| wb_mem_o | output | 1 | Write-back source: 1 memory, 0 ALU |
| alu_op_o | output | 3 | ALU operation code |
| br_eq_o | output | 1 | Branch if operands equal |
| br_ne_o | output | 1 | Branch if operands differ |
| jump_o | output | 1 | Unconditional jump |

## Verification
The hardest case to reach is a field-routing fault that only shows up under one combination of opcode and operand bits. Two examples are a destination mux that picks the wrong field, or a sign extension that copies the wrong bit. Both stay hidden whenever the fields happen to hold equal values. The stimulus therefore crosses all sixteen opcodes with operand patterns that give the three register fields distinct values. It also pushes the offset through both ends of its signed range (0, +31, -32, -1) and through alternating bit patterns. Every reserved code is checked across all the enables.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

    localparam int OPC_W = 4;
    localparam int ALU_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 4'h0,
        OPC_STORE = 4'h1,
        OPC_ADD   = 4'h2,
        OPC_SUB   = 4'h3,
        OPC_INV   = 4'h4,
        OPC_SHL   = 4'h5,
        OPC_SHR   = 4'h6,
        OPC_AND   = 4'h7,
        OPC_OR    = 4'h8,
        OPC_SLT   = 4'h9,
        OPC_RSV_A = 4'hA,
        OPC_BEQ   = 4'hB,
        OPC_BNE   = 4'hC,
        OPC_JMP   = 4'hD,
        OPC_RSV_E = 4'hE,
        OPC_RSV_F = 4'hF
    } opcode_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_INV = 3'd2,
        ALU_SHL = 3'd3,
        ALU_SHR = 3'd4,
        ALU_AND = 3'd5,
        ALU_OR  = 3'd6,
        ALU_SLT = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    mem_rd;
        logic    mem_wr;
        logic    wb_mem;
        alu_op_e alu_op;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
        logic    dst_from_b;
    } ctrl_s;

endpackage

// File: rtl/dec_ctrl.sv
module dec_ctrl
    import isa_dec_pkg::*;
(
    input  opcode_e opc_i,
    output ctrl_s   ctrl_o
);

    ctrl_s ctrl_d;

    always_comb begin
        ctrl_d        = '0;
        ctrl_d.alu_op = ALU_ADD;
        unique case (opc_i)
            OPC_LOAD: begin
                ctrl_d.reg_we     = 1'b1;
                ctrl_d.mem_rd     = 1'b1;
                ctrl_d.wb_mem     = 1'b1;
                ctrl_d.dst_from_b = 1'b1;
            end
            OPC_STORE: ctrl_d.mem_wr = 1'b1;
            OPC_ADD: begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_ADD; end
            OPC_SUB: begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_SUB; end
            OPC_INV: begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_INV; end
            OPC_SHL: begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_SHL; end
            OPC_SHR: begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_SHR; end
            OPC_AND: begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_AND; end
            OPC_OR:  begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_OR;  end
            OPC_SLT: begin ctrl_d.reg_we = 1'b1; ctrl_d.alu_op = ALU_SLT; end
            OPC_BEQ: begin ctrl_d.br_eq  = 1'b1; ctrl_d.alu_op = ALU_SUB; end
            OPC_BNE: begin ctrl_d.br_ne  = 1'b1; ctrl_d.alu_op = ALU_SUB; end
            OPC_JMP: ctrl_d.jump = 1'b1;
            default: ctrl_d = '0;
        endcase
    end

    assign ctrl_o = ctrl_d;

    // Enables that name distinct memory or PC actions never overlap.
    always_comb begin
        p_one_action_r11: assert ($onehot0({ctrl_d.mem_wr, ctrl_d.br_eq, ctrl_d.br_ne, ctrl_d.jump}));
        p_rd_wr_excl_r11: assert (!(ctrl_d.mem_rd && ctrl_d.mem_wr));
        p_reserved_quiet_r10: assert (!((opc_i == OPC_RSV_A || opc_i == OPC_RSV_E || opc_i == OPC_RSV_F)
                                        && (ctrl_d != '0)));
    end

endmodule

// File: rtl/dec_fields.sv
module dec_fields #(
    parameter int BODY_W    = 12,
    parameter int REG_IDX_W = 3,
    parameter int IMM_W     = 6,
    parameter int DATA_W    = 16
) (
    input  logic [BODY_W-1:0]    body_i,
    output logic [REG_IDX_W-1:0] fld_a_o,
    output logic [REG_IDX_W-1:0] fld_b_o,
    output logic [REG_IDX_W-1:0] fld_c_o,
    output logic [DATA_W-1:0]    imm_o
);

    localparam int A_LO = BODY_W - REG_IDX_W;
    localparam int B_LO = A_LO - REG_IDX_W;
    localparam int C_LO = B_LO - REG_IDX_W;

    assign fld_a_o = body_i[A_LO +: REG_IDX_W];
    assign fld_b_o = body_i[B_LO +: REG_IDX_W];
    assign fld_c_o = body_i[C_LO +: REG_IDX_W];

    generate
        if (DATA_W > IMM_W) begin : g_sext
            assign imm_o = {{(DATA_W-IMM_W){body_i[IMM_W-1]}}, body_i[IMM_W-1:0]};
        end else begin : g_trunc
            assign imm_o = body_i[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/isa_decoder.sv
module isa_decoder
    import isa_dec_pkg::*;
#(
    parameter int INSTR_W   = 16,
    parameter int REG_IDX_W = 3,
    parameter int IMM_W     = 6,
    parameter int DATA_W    = 16
) (
    input  logic [INSTR_W-1:0]   instr_i,
    output logic [REG_IDX_W-1:0] src_a_o,
    output logic [REG_IDX_W-1:0] src_b_o,
    output logic [REG_IDX_W-1:0] dst_o,
    output logic [DATA_W-1:0]    imm_o,
    output logic                 reg_we_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic                 wb_mem_o,
    output logic [ALU_W-1:0]     alu_op_o,
    output logic                 br_eq_o,
    output logic                 br_ne_o,
    output logic                 jump_o
);

    localparam int BODY_W = INSTR_W - OPC_W;

    opcode_e               opc;
    ctrl_s                 ctrl;
    logic [REG_IDX_W-1:0]  fld_c;

    assign opc = opcode_e'(instr_i[INSTR_W-1 -: OPC_W]);

    dec_ctrl u_ctrl (
        .opc_i  (opc),
        .ctrl_o (ctrl)
    );

    dec_fields #(
        .BODY_W    (BODY_W),
        .REG_IDX_W (REG_IDX_W),
        .IMM_W     (IMM_W),
        .DATA_W    (DATA_W)
    ) u_fields (
        .body_i  (instr_i[BODY_W-1:0]),
        .fld_a_o (src_a_o),
        .fld_b_o (src_b_o),
        .fld_c_o (fld_c),
        .imm_o   (imm_o)
    );

    assign dst_o    = ctrl.dst_from_b ? src_b_o : fld_c;
    assign reg_we_o = ctrl.reg_we;
    assign mem_rd_o = ctrl.mem_rd;
    assign mem_wr_o = ctrl.mem_wr;
    assign wb_mem_o = ctrl.wb_mem;
    assign alu_op_o = ctrl.alu_op;
    assign br_eq_o  = ctrl.br_eq;
    assign br_ne_o  = ctrl.br_ne;
    assign jump_o   = ctrl.jump;

    always_comb begin
        p_wb_needs_we_r5:  assert (!wb_mem_o || (reg_we_o && mem_rd_o));
        p_jump_no_we_r9:   assert (!jump_o || !reg_we_o);
        p_sext_fill_r3:    assert (imm_o[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){imm_o[IMM_W-1]}});
        p_load_dst_r2:     assert (!mem_rd_o || dst_o == src_b_o);
        p_store_no_we_r6:  assert (!mem_wr_o || !reg_we_o);
    end

endmodule

// File: tb/isa_decoder_bench.sv
`timescale 1ns/1ps
module isa_decoder_bench;

    typedef struct packed {
        logic [2:0]  sa, sb, dst;
        logic [15:0] imm;
        logic        we, rd, wr, wbm;
        logic [2:0]  alu;
        logic        beq, bne, jmp;
    } exp_s;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic [2:0]  sa, sb, dst, alu;
    logic [15:0] imm;
    logic        we, rd, wr, wbm, beq, bne, jmp;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    exp_s        q[$];

    always #10 clk = ~clk;

    isa_decoder u_isa_decoder (
        .instr_i(instr), .src_a_o(sa), .src_b_o(sb), .dst_o(dst), .imm_o(imm),
        .reg_we_o(we), .mem_rd_o(rd), .mem_wr_o(wr), .wb_mem_o(wbm),
        .alu_op_o(alu), .br_eq_o(beq), .br_ne_o(bne), .jump_o(jmp)
    );

    function automatic exp_s model(input logic [15:0] w);
        exp_s e;
        int   op;
        e     = '0;
        op    = int'(w[15:12]);
        e.sa  = w[11:9];
        e.sb  = w[8:6];
        e.imm = {{10{w[5]}}, w[5:0]};
        e.dst = (op == 0) ? w[8:6] : w[5:3];
        if (op == 0) begin e.we = 1; e.rd = 1; e.wbm = 1; end
        if (op == 1) e.wr = 1;
        if (op >= 2 && op <= 9) begin e.we = 1; e.alu = 3'(op - 2); end
        if (op == 11) begin e.beq = 1; e.alu = 3'd1; end
        if (op == 12) begin e.bne = 1; e.alu = 3'd1; end
        if (op == 13) e.jmp = 1;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s instr=%h actual=%h expected=%h", tag, instr, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] w);
        @(posedge clk);
        instr = w;
        q.push_back(model(w));
    endtask

    // Monitor: compares outputs half a cycle after each drive.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_s e;
            e = q.pop_front();
            chk("R1 src_a", 16'(sa), 16'(e.sa));
            chk("R1 src_b", 16'(sb), 16'(e.sb));
            if (e.we) chk("R2 dst", 16'(dst), 16'(e.dst));
            chk("R3 imm", imm, e.imm);
            chk("R4 reg_we", 16'(we), 16'(e.we));
            chk("R5 mem_rd", 16'(rd), 16'(e.rd));
            chk("R5 wb_mem", 16'(wbm), 16'(e.wbm));
            chk("R6 mem_wr", 16'(wr), 16'(e.wr));
            chk("R7 alu_op", 16'(alu), 16'(e.alu));
            chk("R8 br_eq", 16'(beq), 16'(e.beq));
            chk("R8 br_ne", 16'(bne), 16'(e.bne));
            chk("R9 jump", 16'(jmp), 16'(e.jmp));
            chk("R11 exclusive", 16'($countones({wr, beq, bne, jmp}) > 1 || (rd && wr)), 16'd0);
            if (instr[15:12] == 4'hA || instr[15:12] >= 4'hE)
                chk("R10 reserved quiet", 16'({we, rd, wr, wbm, beq, bne, jmp, alu}), 16'd0);
        end
    end

    initial begin
        logic [11:0] pats [8];
        pats[0] = 12'b000_000_000000;
        pats[1] = 12'b001_010_011_111;  // fields 1,2,3; imm +31
        pats[2] = 12'b110_101_100_000;  // fields 6,5,4; imm -32
        pats[3] = 12'b111_111_111111;   // imm -1
        pats[4] = 12'b010_100_011_111;
        pats[5] = 12'b101_010_101010;
        pats[6] = 12'b011_110_001_101;
        pats[7] = 12'b100_001_110_011;
        // Reset state: word zero decodes as a load.
        #5;
        n_run++;
        if (!(we && rd && wbm && !wr && alu == 3'd0)) begin
            n_fail++;
            $display("FAIL R5 reset-time word 0: we=%b rd=%b wbm=%b expected 1 1 1", we, rd, wbm);
        end
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        for (int op = 0; op < 16; op++)
            for (int p = 0; p < 8; p++)
                drive({4'(op), pats[p]});
        for (int k = 0; k < 64; k++)
            drive({4'(k % 16), 12'(k * 37 + 5)});
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #1_000_000;
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule